// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block performs the hardware steps of accepting a maskable interrupt on behalf of a processor core. When a request arrives with a vector number and the status word has interrupts enabled, the sequencer snapshots the core's status word, program counter, stack pointer, saved kernel stack pointer and exception base, then drives a short, fixed series of register-write strobes back into the core's register file. Those writes leave kernel mode, rebuild the status word, swap stacks, record the return address and the exception cause, and finally load the handler address.

The handler address comes from a vector table in memory. The sequencer issues one word read over a request/acknowledge port and waits in a dedicated state until the memory either acknowledges with data or reports an error. On success the new program counter is written; on error an access-error pulse is raised and the program counter is left alone. Either way a one-cycle completion pulse closes the sequence.

The core applies each output value to its register in any cycle where the matching write strobe is high; values on the data outputs are meaningful only alongside their strobe.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset every write strobe, `memReq`, `done` and `accessErr` are low, and they stay low while no request is accepted.
- R2: A request is accepted only when bit 4 (interrupt enable) of `statusIn` is set in the cycle `irqReq` is high; otherwise it has no effect on any output. Requests arriving while a sequence is in progress are also ignored.
- R3: The cycle after acceptance writes the status word with only bit 5 (user mode) cleared and all other bits as captured; no other strobe is high in that cycle.
- R4: The following cycle writes the status word as the captured word shifted left by 10, bits 31 and 30 of the shifted value dropped, and bit 31 of the captured word placed back at bit 31.
- R5: In that same cycle the stack pointer is written with the captured kernel stack pointer, and the user stack pointer is written with the captured stack pointer only when bit 5 of the captured status was set.
- R6: In that same cycle the return-address register is written with the captured PC, the exception-status register with vector × 256, and the exception-data-address register with zero.
- R7: The next cycle raises `memReq` with `memAddr` = exception base + vector × 4; request and address stay unchanged until `memAck` or `memErr` is seen.
- R8: After `memAck`, the next cycle writes the PC with the returned word, whose bits 7:0 hold the byte at the lowest address (little-endian).
- R9: After `memErr`, the next cycle raises `accessErr` for one cycle and does not write the PC.
- R10: `done` is high for exactly one cycle, the cycle after the memory response, whether the read succeeded or failed, and the block then accepts new requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 1 | Interrupt request |
| irqVec | input | 8 | Interrupt vector number |
| statusIn | input | 32 | Current status word |
| pcIn | input | 32 | Current program counter |
| spIn | input | 32 | Current stack pointer |
| kspIn | input | 32 | Saved kernel stack pointer |
| ebaseIn | input | 32 | Exception vector table base |
| memReq | output | 1 | Vector read request |
| memAddr | output | 32 | Vector read address |
| memRdata | input | 32 | Vector read data, lowest-address byte in bits 7:0 |
| memAck | input | 1 | Read completed with data |
| memErr | input | 1 | Read failed |
| statusWe | output | 1 | Status word write strobe |
| statusOut | output | 32 | Status word value |
| spWe | output | 1 | Stack pointer write strobe |
| spOut | output | 32 | Stack pointer value |
| uspWe | output | 1 | User stack pointer write strobe |
| uspOut | output | 32 | User stack pointer value |
| erpWe | output | 1 | Return-address write strobe |
| erpOut | output | 32 | Return-address value |
| exsWe | output | 1 | Exception-status write strobe |
| exsOut | output | 32 | Exception-status value |
| edaWe | output | 1 | Exception-data-address write strobe |
| edaOut | output | 32 | Exception-data-address value |
| pcWe | output | 1 | Program counter write strobe |
| pcOut | output | 32 | Handler address |
| accessErr | output | 1 | Vector read failed |
| done | output | 1 | Sequence finished |

## Verification
The assertions take for granted that the memory raises `memAck` or `memErr` only while `memReq` is high, never both in the same cycle, and drops them once the request falls. The bench's memory responder answers only a pending request, picks exactly one of the two responses from the address (a top nibble of F means error) and clears its response on the next half-cycle. Register snapshot inputs are held steady around the acceptance edge, and the bench also toggles them during a sequence to show that only the captured values matter.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_KOFF  = 3'd1,
    ST_SAVE  = 3'd2,
    ST_FETCH = 3'd3,
    ST_FIN   = 3'd4
  } seqState_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic capture;    // snapshot inputs
    logic kernelOff;  // write status with user bit cleared
    logic commit;     // write rebuilt status and saved registers
    logic fetch;      // vector read outstanding
    logic grab;       // latch memory response
    logic finish;     // final cycle
  } seqStrobe_t;

endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       irqReq,
  input  logic       ieBit,
  input  logic       memAck,
  input  logic       memErr,
  output seqStrobe_t strb,
  output logic       memReq,
  output logic       done
);

  seqState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:  if (irqReq && ieBit) stateNxt = ST_KOFF;
      ST_KOFF:  stateNxt = ST_SAVE;
      ST_SAVE:  stateNxt = ST_FETCH;
      ST_FETCH: if (memAck || memErr) stateNxt = ST_FIN;
      ST_FIN:   stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    strb           = '0;
    strb.capture   = (state == ST_IDLE) && irqReq && ieBit;
    strb.kernelOff = (state == ST_KOFF);
    strb.commit    = (state == ST_SAVE);
    strb.fetch     = (state == ST_FETCH);
    strb.grab      = (state == ST_FETCH) && (memAck || memErr);
    strb.finish    = (state == ST_FIN);
  end

  assign memReq = strb.fetch;
  assign done   = strb.finish;

  // R2: masked request leaves the sequencer idle
  p_masked_ignored_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && irqReq && !ieBit) |=> (state == ST_IDLE));

  // R3: the rebuild of the status word is always preceded by the user-bit clear
  p_koff_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> $past(strb.kernelOff));

  // R7: the read request holds until a response arrives
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !memErr) |=> memReq);

  // R10: done is a single-cycle pulse following a memory response
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_after_resp_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(memReq && (memAck || memErr)));

endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int VEC_W      = 8,
  parameter int STAT_SHIFT = 10,
  parameter int STAT_KEEP  = 30,
  parameter int USR_BIT    = 5,
  parameter int EXS_SHIFT  = 8,
  parameter int ADDR_SHIFT = 2
)(
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic [VEC_W-1:0] irqVec,
  input  logic [XLEN-1:0]  statusIn,
  input  logic [XLEN-1:0]  pcIn,
  input  logic [XLEN-1:0]  spIn,
  input  logic [XLEN-1:0]  kspIn,
  input  logic [XLEN-1:0]  ebaseIn,
  input  logic [XLEN-1:0]  memRdata,
  input  logic             memAck,
  input  logic             memErr,
  output logic [XLEN-1:0]  memAddr,
  output logic             statusWe,
  output logic [XLEN-1:0]  statusOut,
  output logic             spWe,
  output logic [XLEN-1:0]  spOut,
  output logic             uspWe,
  output logic [XLEN-1:0]  uspOut,
  output logic             erpWe,
  output logic [XLEN-1:0]  erpOut,
  output logic             exsWe,
  output logic [XLEN-1:0]  exsOut,
  output logic             edaWe,
  output logic [XLEN-1:0]  edaOut,
  output logic             pcWe,
  output logic [XLEN-1:0]  pcOut,
  output logic             accessErr
);

  localparam int TOP_BIT = XLEN - 1;
  localparam logic [XLEN-1:0] KEEP_MASK = {{(XLEN-STAT_KEEP){1'b0}}, {STAT_KEEP{1'b1}}};
  localparam logic [XLEN-1:0] TOP_MASK  = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] USR_MASK  = XLEN'(1) << USR_BIT;

  logic [XLEN-1:0]  capStat, capPc, capSp, capKsp, capBase, handler;
  logic [VEC_W-1:0] capVec;
  logic             faulted;
  logic [XLEN-1:0]  rebuiltStat, vecWide;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capStat <= '0;
      capPc   <= '0;
      capSp   <= '0;
      capKsp  <= '0;
      capBase <= '0;
      capVec  <= '0;
    end else if (strb.capture) begin
      capStat <= statusIn;
      capPc   <= pcIn;
      capSp   <= spIn;
      capKsp  <= kspIn;
      capBase <= ebaseIn;
      capVec  <= irqVec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      handler <= '0;
      faulted <= 1'b0;
    end else if (strb.grab) begin
      handler <= memRdata;
      faulted <= memErr;
    end
  end

  assign vecWide     = XLEN'(capVec);
  assign rebuiltStat = ((capStat << STAT_SHIFT) & KEEP_MASK) | (capStat & TOP_MASK);

  assign statusWe  = strb.kernelOff | strb.commit;
  assign statusOut = strb.kernelOff ? (capStat & ~USR_MASK) : rebuiltStat;

  assign spWe   = strb.commit;
  assign spOut  = capKsp;
  assign uspWe  = strb.commit & capStat[USR_BIT];
  assign uspOut = capSp;
  assign erpWe  = strb.commit;
  assign erpOut = capPc;
  assign exsWe  = strb.commit;
  assign exsOut = vecWide << EXS_SHIFT;
  assign edaWe  = strb.commit;
  assign edaOut = '0;

  assign memAddr = capBase + (vecWide << ADDR_SHIFT);

  assign pcWe      = strb.finish & ~faulted;
  assign pcOut     = handler;
  assign accessErr = strb.finish & faulted;

  // R4: the rebuilt status keeps the captured top bit
  p_top_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (statusOut[TOP_BIT] == capStat[TOP_BIT]));

  // R6: cause value carries the vector above the low byte
  p_exs_low_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    exsWe |-> (exsOut[EXS_SHIFT-1:0] == '0));

  // R7: address stays put while the read is pending
  p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fetch && !memAck && !memErr) |=> $stable(memAddr));

  // R9: a failed read never writes the PC
  p_err_no_pc_r9: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |-> !pcWe);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int VEC_W      = 8,
  parameter int STAT_SHIFT = 10,
  parameter int STAT_KEEP  = 30,
  parameter int IEN_BIT    = 4,
  parameter int USR_BIT    = 5
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             irqReq,
  input  logic [VEC_W-1:0] irqVec,
  input  logic [XLEN-1:0]  statusIn,
  input  logic [XLEN-1:0]  pcIn,
  input  logic [XLEN-1:0]  spIn,
  input  logic [XLEN-1:0]  kspIn,
  input  logic [XLEN-1:0]  ebaseIn,
  output logic             memReq,
  output logic [XLEN-1:0]  memAddr,
  input  logic [XLEN-1:0]  memRdata,
  input  logic             memAck,
  input  logic             memErr,
  output logic             statusWe,
  output logic [XLEN-1:0]  statusOut,
  output logic             spWe,
  output logic [XLEN-1:0]  spOut,
  output logic             uspWe,
  output logic [XLEN-1:0]  uspOut,
  output logic             erpWe,
  output logic [XLEN-1:0]  erpOut,
  output logic             exsWe,
  output logic [XLEN-1:0]  exsOut,
  output logic             edaWe,
  output logic [XLEN-1:0]  edaOut,
  output logic             pcWe,
  output logic [XLEN-1:0]  pcOut,
  output logic             accessErr,
  output logic             done
);

  seqStrobe_t strb;
  logic       ieBit;

  assign ieBit = statusIn[IEN_BIT];

  irq_entry_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .irqReq (irqReq),
    .ieBit  (ieBit),
    .memAck (memAck),
    .memErr (memErr),
    .strb   (strb),
    .memReq (memReq),
    .done   (done)
  );

  irq_entry_dp #(
    .XLEN       (XLEN),
    .VEC_W      (VEC_W),
    .STAT_SHIFT (STAT_SHIFT),
    .STAT_KEEP  (STAT_KEEP),
    .USR_BIT    (USR_BIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .irqVec    (irqVec),
    .statusIn  (statusIn),
    .pcIn      (pcIn),
    .spIn      (spIn),
    .kspIn     (kspIn),
    .ebaseIn   (ebaseIn),
    .memRdata  (memRdata),
    .memAck    (memAck),
    .memErr    (memErr),
    .memAddr   (memAddr),
    .statusWe  (statusWe),
    .statusOut (statusOut),
    .spWe      (spWe),
    .spOut     (spOut),
    .uspWe     (uspWe),
    .uspOut    (uspOut),
    .erpWe     (erpWe),
    .erpOut    (erpOut),
    .exsWe     (exsWe),
    .exsOut    (exsOut),
    .edaWe     (edaWe),
    .edaOut    (edaOut),
    .pcWe      (pcWe),
    .pcOut     (pcOut),
    .accessErr (accessErr)
  );

endmodule

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irqReq = 1'b0;
  logic [7:0]  irqVec = '0;
  logic [31:0] statusIn = '0, pcIn = '0, spIn = '0, kspIn = '0, ebaseIn = '0;
  logic        memReq;
  logic [31:0] memAddr;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0, memErr = 1'b0;
  logic        statusWe, spWe, uspWe, erpWe, exsWe, edaWe, pcWe, accessErr, done;
  logic [31:0] statusOut, spOut, uspOut, erpOut, exsOut, edaOut, pcOut;

  integer tests = 0, fails = 0;
  integer latency = 0;
  integer waitCnt = 0;
  bit     finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_entry_seq dut (.*);

  function automatic logic [31:0] tableWord(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A00_C3A5;
  endfunction

  // memory responder: answers a pending request after 'latency' waits
  always @(negedge clk) begin
    memAck <= 1'b0;
    memErr <= 1'b0;
    if (memReq) begin
      if (waitCnt == latency) begin
        waitCnt <= 0;
        if (memAddr[31:28] == 4'hF) memErr <= 1'b1;
        else begin
          memAck   <= 1'b1;
          memRdata <= tableWord(memAddr);
        end
      end else waitCnt <= waitCnt + 1;
    end else waitCnt <= 0;
  end

  // behavioural reference
  integer      mPhase = 0;
  logic [31:0] mStat, mPc, mSp, mKsp, mBase, mHandler;
  logic [7:0]  mVec;
  logic        mErr;

  always @(posedge clk) begin
    if (!rstN) mPhase = 0;
    else case (mPhase)
      0: if (irqReq && statusIn[4]) begin
           mStat = statusIn; mPc = pcIn; mSp = spIn; mKsp = kspIn;
           mBase = ebaseIn; mVec = irqVec; mPhase = 1;
         end
      1: mPhase = 2;
      2: mPhase = 3;
      3: if (memAck || memErr) begin
           mErr = memErr; mHandler = memRdata; mPhase = 4;
         end
      default: mPhase = 0;
    endcase
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      case (mPhase)
        0: begin
          chk("R2 quiet strobes", {25'd0, statusWe, spWe, uspWe, erpWe, exsWe, edaWe, pcWe}, 32'd0);
          chk("R2 quiet req", {29'd0, memReq, accessErr, done}, 32'd0);
        end
        1: begin
          chk("R3 only status strobe", {25'd0, statusWe, spWe, uspWe, erpWe, exsWe, edaWe, pcWe}, 32'h40);
          chk("R3 user bit cleared", statusOut, mStat & ~32'h20);
          chk("R3 no req", {29'd0, memReq, accessErr, done}, 32'd0);
        end
        2: begin
          chk("R4 status we", {31'd0, statusWe}, 32'd1);
          chk("R4 rebuilt status", statusOut,
              ((mStat << 10) & 32'h3FFF_FFFF) | (mStat & 32'h8000_0000));
          chk("R5 sp we", {31'd0, spWe}, 32'd1);
          chk("R5 sp value", spOut, mKsp);
          chk("R5 usp we", {31'd0, uspWe}, {31'd0, mStat[5]});
          if (mStat[5]) chk("R5 usp value", uspOut, mSp);
          chk("R6 erp/exs/eda we", {29'd0, erpWe, exsWe, edaWe}, 32'd7);
          chk("R6 erp value", erpOut, mPc);
          chk("R6 exs value", exsOut, {16'd0, mVec, 8'd0});
          chk("R6 eda value", edaOut, 32'd0);
          chk("R6 no req", {30'd0, memReq, pcWe}, 32'd0);
        end
        3: begin
          chk("R7 req high", {31'd0, memReq}, 32'd1);
          chk("R7 address", memAddr, mBase + {22'd0, mVec, 2'b00});
          chk("R7 no strobes", {25'd0, statusWe, spWe, uspWe, erpWe, exsWe, edaWe, pcWe}, 32'd0);
        end
        default: begin
          chk("R10 done", {31'd0, done}, 32'd1);
          chk("R8 pc we", {31'd0, pcWe}, {31'd0, !mErr});
          if (!mErr) chk("R8 handler", pcOut, mHandler);
          chk("R9 access err", {31'd0, accessErr}, {31'd0, mErr});
          chk("R10 req dropped", {31'd0, memReq}, 32'd0);
        end
      endcase
    end
  end

  task automatic runSeq(input logic [31:0] st, input logic [31:0] pc, input logic [31:0] sp,
                        input logic [31:0] ksp, input logic [31:0] base, input logic [7:0] vec,
                        input integer lat, input bit holdReq);
    @(negedge clk);
    latency  = lat;
    statusIn = st; pcIn = pc; spIn = sp; kspIn = ksp; ebaseIn = base; irqVec = vec;
    irqReq   = 1'b1;
    @(negedge clk);
    irqReq = holdReq;
    // disturb the live inputs: only the captured copy may matter
    statusIn = ~st; pcIn = pc ^ 32'h1111_0000; kspIn = ~ksp; irqVec = vec + 8'd3;
    repeat (lat + 5) @(negedge clk);
    irqReq = 1'b0;
    statusIn = '0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset strobes", {25'd0, statusWe, spWe, uspWe, erpWe, exsWe, edaWe, pcWe}, 32'd0);
    chk("R1 reset req/done", {29'd0, memReq, accessErr, done}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2: masked request ignored (enable bit 4 clear, user bit set)
    @(negedge clk);
    statusIn = 32'hFFFF_FFEF; irqVec = 8'h12; irqReq = 1'b1;
    repeat (4) @(negedge clk);
    irqReq = 1'b0; statusIn = '0;
    repeat (2) @(negedge clk);

    // user mode, immediate ack (R3..R8, R10)
    runSeq(32'h8000_0031, 32'h0000_1234, 32'h0000_8000, 32'h0001_0000, 32'h0000_4000, 8'h05, 0, 1'b0);
    // kernel mode, bit31 clear, slow memory
    runSeq(32'h4ABC_DE17, 32'hCAFE_0000, 32'h0000_7FF0, 32'h0002_0000, 32'h1000_0000, 8'hFF, 3, 1'b0);
    // vector zero, request held through the sequence
    runSeq(32'hFFFF_FFFF, 32'h0000_0002, 32'h1234_5678, 32'h8765_4320, 32'h2000_0100, 8'h00, 1, 1'b1);
    // R9: failing vector read
    runSeq(32'h0000_0010, 32'h0000_ABCD, 32'h0000_1000, 32'h0000_2000, 32'hF000_0000, 8'h20, 2, 1'b0);
    // back-to-back after error still works (R10)
    runSeq(32'h0000_0030, 32'h0000_0100, 32'h0000_3000, 32'h0000_4000, 32'h0000_0800, 8'h80, 6, 1'b0);
    runSeq(32'h8000_0010, 32'h7FFF_FFFE, 32'h0, 32'hFFFF_FFF0, 32'hEFFF_FFFC, 8'h01, 0, 1'b1);

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule